// File: doc/BRIEF.md
# Interval Timer with Oscillator Stabilization Wait

This block is a free-running interval timer clocked by the system clock. A long binary chain counts every cycle; its low part acts as a prescaler and its top stage is the visible 8-bit timer count. A three-bit wait code, held in a 4-bit mode register, picks one tap of the chain. Each wrap of the bits below that tap raises a one-cycle interval interrupt request, so the code sets both the interrupt period and the settling delay.

After a standby release the CPU must not run until the oscillator has settled. The block starts that wait from zero and drives a CPU hold output until the selected tap wraps for the first time. A release by reset loads the default code, so the reset wait has a fixed length. A release by interrupt uses whatever code software last wrote. The same timer also serves as a watchdog. The first service strobe arms it. From then on, a tap wrap that happens without a service strobe in between produces a reset pulse.

Top module: `stab_wait_timer`

## Requirements
- R1: While reset is low and in the first cycle after it, `tmr_count` is 0, `cpu_hold` is 1, and `irq_interval` and `wdt_reset` are 0.
- R2: Reset loads wait code 3'b011. After reset is released, `cpu_hold` stays 1 for exactly 2^WAIT_EXP1 cycles.
- R3: A `wake_req` pulse zeroes the chain and sets `cpu_hold` at the next edge. `cpu_hold` then stays 1 for exactly 2^E cycles, falling in the same cycle as an interval pulse. E is WAIT_EXP0 for code 3'b000, WAIT_EXP1 for 3'b011, WAIT_EXP2 for 3'b101 and WAIT_EXP3 for 3'b111.
- R4: A mode write takes its code from `mode_wdata[2:0]`. Codes 3'b001, 3'b010, 3'b100 and 3'b110 give the same wait and interval as 3'b111.
- R5: `mode_wdata[3]` has no effect on the wait length. A mode write with that bit set zeroes the whole chain at that edge, so `tmr_count` reads 0 in the following cycle.
- R6: `irq_interval` is a one-cycle pulse. It is raised in the cycle after the low E bits of the chain wrap from all ones, so with no clears it repeats every 2^E cycles.
- R7: `tmr_count` equals the top CNT_W bits of a chain of PRE_W+CNT_W bits. The chain increments by one each cycle unless a wake, a service strobe or a clearing mode write zeroes it.
- R8: `wdt_reset` is never raised before the first `wdt_kick` after reset. Each kick zeroes the chain. Once armed, `wdt_reset` pulses together with `irq_interval` on every tap wrap, 2^E+1 sampled cycles after the last kick.
- R9: A `wake_req` while `cpu_hold` is already 1 restarts the wait, which again lasts a full 2^E cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also the reset-type standby release |
| wake_req | input | 1 | Standby release by interrupt request, one-cycle strobe |
| mode_we | input | 1 | Mode register write enable |
| mode_wdata | input | 4 | Mode write data: [2:0] wait code, [3] chain clear |
| wdt_kick | input | 1 | Watchdog service strobe; arms the watchdog and zeroes the chain |
| tmr_count | output | CNT_W | Visible top stage of the chain |
| irq_interval | output | 1 | Interval interrupt request, one-cycle pulse |
| wdt_reset | output | 1 | Watchdog reset pulse |
| cpu_hold | output | 1 | High while the CPU must stay stopped |

## Verification
The embedded properties check several rules on every cycle. They check that every clear source leaves the chain at zero, and that the chain otherwise advances by exactly one. They check that mode writes latch the code and that a wake sets the hold. They also check that the hold only falls together with an interval pulse, that interval pulses last one cycle, and that a watchdog pulse never occurs without an interval pulse. Other behaviour can only be shown by the bench's scenarios against its cycle model. This covers the exact wait lengths for each code, the fallback of unlisted codes, the reset wait, and the restart of a wait already in progress. It also covers the disarmed watchdog before the first kick, and how wakes, kicks and clearing writes interleave under random stimulus.

// File: rtl/swt_pkg.sv
// Package: shared types and the wait-code decode for the stabilization-wait timer.
// Assumes four supported wait lengths, indexed 0 (longest) to 3 (shortest).
package swt_pkg;

    typedef enum logic [2:0] {
        WC_LONG  = 3'b000,
        WC_RESET = 3'b011,
        WC_MID   = 3'b101,
        WC_SHORT = 3'b111
    } wait_code_e;

    typedef logic [1:0] tap_sel_t;

    // Maps a wait code to its tap index; unlisted codes fall back to the shortest.
    function automatic tap_sel_t code_to_sel(input logic [2:0] code);
        tap_sel_t sel;
        case (code)
            WC_LONG:  sel = 2'd0;
            WC_RESET: sel = 2'd1;
            WC_MID:   sel = 2'd2;
            default:  sel = 2'd3;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/swt_mode_reg.sv
// Mode register: holds the 3-bit wait code and turns bit 3 of a write into a
// one-cycle chain clear. Assumes writes are single-cycle strobes; bit 3 is not stored.
module swt_mode_reg
    import swt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [3:0] wdata_i,
    output tap_sel_t   sel_o,
    output logic       clr_o
);

    logic [2:0] mode_q;

    // Latch the wait code; reset selects the reset-release wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WC_RESET;
        end else if (we_i) begin
            mode_q <= wdata_i[2:0];
        end
    end

    // Decode the stored code to a tap index.
    always_comb begin
        sel_o = code_to_sel(mode_q);
    end

    // A write with the clear bit set zeroes the chain at the same edge.
    assign clr_o = we_i & wdata_i[3];

    assert_mode_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mode_q == $past(wdata_i[2:0])));

endmodule

// File: rtl/swt_chain.sv
// Counting chain: prescaler (PRE_W bits) followed by the visible stage (CNT_W bits).
// Reports a wrap of the low bits below the selected tap. Assumes 1 <= WAIT_EXPn <= PRE_W+CNT_W.
module swt_chain
    import swt_pkg::*;
#(
    parameter int unsigned PRE_W     = 12,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned WAIT_EXP0 = 20,
    parameter int unsigned WAIT_EXP1 = 17,
    parameter int unsigned WAIT_EXP2 = 15,
    parameter int unsigned WAIT_EXP3 = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  tap_sel_t         sel_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    localparam int unsigned CH_W   = PRE_W + CNT_W;
    localparam int unsigned N_TAPS = 4;

    logic [CH_W-1:0]   chain_q;
    logic [N_TAPS-1:0] tap_full;

    // One all-ones detector per selectable tap.
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int unsigned TAP_E = (i == 0) ? WAIT_EXP0 :
                                        (i == 1) ? WAIT_EXP1 :
                                        (i == 2) ? WAIT_EXP2 : WAIT_EXP3;
        assign tap_full[i] = &chain_q[TAP_E-1:0];
    end

    // Advance the chain every cycle; any clear source wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_q + 1'b1;
        end
    end

    assign wrap_o  = !clr_i && tap_full[sel_i];
    assign count_o = chain_q[CH_W-1 -: CNT_W];

    assert_clear_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (chain_q == '0));

    assert_chain_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (chain_q == $past(chain_q) + 1'b1));

endmodule

// File: rtl/swt_events.sv
// Event logic: CPU hold flag, interval interrupt pulse and watchdog pulse.
// Assumes wrap_i is a single-cycle indication of a tap wrap.
module swt_events (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic kick_i,
    input  logic wrap_i,
    output logic hold_o,
    output logic irq_o,
    output logic wdt_o
);

    logic hold_q;
    logic arm_q;
    logic irq_q;
    logic wdt_q;

    // Hold the CPU from reset or a wake until the first tap wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
        end else if (wake_i) begin
            hold_q <= 1'b1;
        end else if (wrap_i) begin
            hold_q <= 1'b0;
        end
    end

    // Arm the watchdog on the first service strobe; only reset disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (kick_i) begin
            arm_q <= 1'b1;
        end
    end

    // Register the interval and watchdog pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            wdt_q <= 1'b0;
        end else begin
            irq_q <= wrap_i;
            wdt_q <= wrap_i & arm_q;
        end
    end

    assign hold_o = hold_q;
    assign irq_o  = irq_q;
    assign wdt_o  = wdt_q;

    assert_hold_on_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> hold_q);

    assert_hold_ends_on_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> irq_q);

    assert_irq_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    assert_wdt_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_q |-> irq_q);

endmodule

// File: rtl/stab_wait_timer.sv
// Top: interval timer with oscillator stabilization wait and watchdog.
// Assumes single-cycle strobes on wake_req, mode_we and wdt_kick. Any clear
// source zeroes the chain at the edge where it is seen.
module stab_wait_timer #(
    parameter int unsigned PRE_W     = 12,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned WAIT_EXP0 = 20,
    parameter int unsigned WAIT_EXP1 = 17,
    parameter int unsigned WAIT_EXP2 = 15,
    parameter int unsigned WAIT_EXP3 = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_req,
    input  logic             mode_we,
    input  logic [3:0]       mode_wdata,
    input  logic             wdt_kick,
    output logic [CNT_W-1:0] tmr_count,
    output logic             irq_interval,
    output logic             wdt_reset,
    output logic             cpu_hold
);

    import swt_pkg::*;

    tap_sel_t sel;
    logic     mode_clr;
    logic     chain_clr;
    logic     wrap;

    // Merge every source that restarts the chain.
    assign chain_clr = mode_clr | wake_req | wdt_kick;

    swt_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mode_we),
        .wdata_i (mode_wdata),
        .sel_o   (sel),
        .clr_o   (mode_clr)
    );

    swt_chain #(
        .PRE_W     (PRE_W),
        .CNT_W     (CNT_W),
        .WAIT_EXP0 (WAIT_EXP0),
        .WAIT_EXP1 (WAIT_EXP1),
        .WAIT_EXP2 (WAIT_EXP2),
        .WAIT_EXP3 (WAIT_EXP3)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (chain_clr),
        .sel_i   (sel),
        .count_o (tmr_count),
        .wrap_o  (wrap)
    );

    swt_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .wake_i (wake_req),
        .kick_i (wdt_kick),
        .wrap_i (wrap),
        .hold_o (cpu_hold),
        .irq_o  (irq_interval),
        .wdt_o  (wdt_reset)
    );

endmodule

// File: tb/stab_wait_timer_bench.sv
`timescale 1ns/1ps
module stab_wait_timer_bench;

    localparam int PRE_W = 4;
    localparam int CNT_W = 8;
    localparam int E0 = 12;
    localparam int E1 = 9;
    localparam int E2 = 7;
    localparam int E3 = 5;
    localparam int CH_W = PRE_W + CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wake_req = 1'b0;
    logic             mode_we = 1'b0;
    logic [3:0]       mode_wdata = 4'd0;
    logic             wdt_kick = 1'b0;
    logic [CNT_W-1:0] tmr_count;
    logic             irq_interval;
    logic             wdt_reset;
    logic             cpu_hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [CH_W-1:0] m_chain;
    logic [2:0]      m_mode;
    logic            m_hold, m_arm, m_irq, m_wdt;
    bit              m_valid = 1'b0;

    always #2.5 clk = ~clk;

    stab_wait_timer #(
        .PRE_W(PRE_W), .CNT_W(CNT_W),
        .WAIT_EXP0(E0), .WAIT_EXP1(E1), .WAIT_EXP2(E2), .WAIT_EXP3(E3)
    ) u_stab_wait_timer (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .wdt_kick(wdt_kick), .tmr_count(tmr_count),
        .irq_interval(irq_interval), .wdt_reset(wdt_reset), .cpu_hold(cpu_hold)
    );

    // Wait exponent per code, straight from the requirements (R3, R4).
    function automatic int exp_of(input logic [2:0] code);
        case (code)
            3'b000:  return E0;
            3'b011:  return E1;
            3'b101:  return E2;
            default: return E3;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs driven for that edge.
    task automatic model_next(input logic r, w, we, input logic [3:0] wd, input logic k);
        logic [CH_W-1:0] mask;
        logic clr, ovf;
        if (!r) begin
            m_chain = '0; m_mode = 3'b011; m_hold = 1'b1;
            m_arm = 1'b0; m_irq = 1'b0; m_wdt = 1'b0;
            m_valid = 1'b1;
        end else if (m_valid) begin
            mask = CH_W'((64'd1 << exp_of(m_mode)) - 1);
            clr = w | k | (we & wd[3]);
            ovf = !clr && ((m_chain & mask) == mask);
            m_irq = ovf;
            m_wdt = ovf & m_arm;
            if (w) m_hold = 1'b1;
            else if (ovf) m_hold = 1'b0;
            if (k) m_arm = 1'b1;
            m_chain = clr ? '0 : m_chain + 1'b1;
            if (we) m_mode = wd[2:0];
        end
    endtask

    // One cycle: compare outputs with the model, then drive the next inputs.
    task automatic step(input logic r, w, we, input logic [3:0] wd, input logic k);
        @(negedge clk);
        if (m_valid) begin
            chk("R7 tmr_count", int'(tmr_count), int'(m_chain[CH_W-1 -: CNT_W]));
            chk("R6 irq_interval", int'(irq_interval), int'(m_irq));
            chk("R8 wdt_reset", int'(wdt_reset), int'(m_wdt));
            chk("R3 cpu_hold", int'(cpu_hold), int'(m_hold));
        end
        rst_n = r; wake_req = w; mode_we = we; mode_wdata = wd; wdt_kick = k;
        model_next(r, w, we, wd, k);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
    endtask

    task automatic measure_hold(output int n);
        n = 0;
        for (int i = 0; i < 10000; i++) begin
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
            if (!cpu_hold) break;
            n++;
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 10000; i++) begin
            if (irq_interval) break;
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int n;
        logic [2:0] codes [8] = '{3'b000, 3'b011, 3'b101, 3'b111,
                                  3'b001, 3'b010, 3'b100, 3'b110};
        void'($urandom(32'd20250611));

        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 4'd0, 1'b0);
        chk("R1 count in reset", int'(tmr_count), 0);
        chk("R1 hold in reset", int'(cpu_hold), 1);
        chk("R1 irq in reset", int'(irq_interval), 0);
        chk("R1 wdt in reset", int'(wdt_reset), 0);

        // R2: reset-release wait uses code 011
        measure_hold(n);
        chk("R2 reset wait length", n, 1 << E1);

        // R3/R4: wait length for every code
        foreach (codes[c]) begin
            step(1'b1, 1'b0, 1'b1, {1'b0, codes[c]}, 1'b0);
            step(1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
            measure_hold(n);
            chk((c < 4) ? "R3 wake wait length" : "R4 unlisted code wait", n, 1 << exp_of(codes[c]));
        end

        // R5: bit 3 ignored for wait length, but clears the chain
        step(1'b1, 1'b0, 1'b1, 4'b1000, 1'b0);
        step(1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
        measure_hold(n);
        chk("R5 bit3 ignored for wait", n, 1 << E0);
        idle(300);
        chk("R5 count nonzero before clear", int'(tmr_count != 0), 1);
        step(1'b1, 1'b0, 1'b1, 4'b1111, 1'b0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
        chk("R5 count zero after clear", int'(tmr_count), 0);

        // R6: interval period and pulse width with code 101
        step(1'b1, 1'b0, 1'b1, 4'b0101, 1'b0);
        wait_irq();
        step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
        chk("R6 pulse one cycle", int'(irq_interval), 0);
        n = 1;
        for (int i = 0; i < 10000; i++) begin
            if (irq_interval) break;
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
            n++;
        end
        chk("R6 interval period", n, 1 << E2);

        // R8: disarmed watchdog after reset
        step(1'b0, 1'b0, 1'b0, 4'd0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 4'b0111, 1'b0);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
            if (wdt_reset) n++;
        end
        chk("R8 no wdt before kick", n, 0);
        step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
            n++;
            if (wdt_reset) break;
        end
        chk("R8 wdt timeout after kick", n, (1 << E3) + 1);
        chk("R8 wdt with irq", int'(irq_interval), 1);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0, 1'b0, 4'd0, 1'b1);
            for (int j = 0; j < 20; j++) begin
                step(1'b1, 1'b0, 1'b0, 4'd0, 1'b0);
                if (wdt_reset) n++;
            end
        end
        chk("R8 serviced watchdog quiet", n, 0);

        // R9: wake during an active wait restarts it
        step(1'b1, 1'b0, 1'b1, 4'b0101, 1'b0);
        step(1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
        idle(50);
        step(1'b1, 1'b1, 1'b0, 4'd0, 1'b0);
        measure_hold(n);
        chk("R9 restarted wait length", n, 1 << E2);

        // Random mix, checked each cycle against the model (R3 R6 R7 R8)
        for (int i = 0; i < 30000; i++) begin
            int r;
            logic w, we, k, rs;
            r  = int'($urandom % 1000);
            rs = (r == 999) ? 1'b0 : 1'b1;
            w  = (r < 4);
            k  = (r >= 4 && r < 10);
            we = (r >= 10 && r < 20);
            step(rs, w, we, 4'($urandom), k);
        end

        finished = 1'b1;
        report();
    end

    // Watchdog for a hung run
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

endmodule